// File: doc/BRIEF.md
# Byte-Lane Memory Chip-Select Decoder

This block joins a 16-bit processor bus to two pairs of 8-bit memory devices. The processor presents a word address, which is byte address bits 23 down to 1; bit 0 never reaches the bus. Two active-low byte strobes say which half of the word the access uses. Each memory region holds two chips side by side. The even-address chip sits on bus lane 7..0 and the odd-address chip sits on bus lane 15..8. Both chips get the same low word-address bits as their own chip address.

The decoder compares the high word-address bits with each region's base. It then drives active-low chip-select, output-enable and write-enable for each chip. A chip is enabled only when the address falls in its region and its own byte strobe is low. One region is writable RAM and the other is read-only ROM. The block also steers write data onto the chip lanes and gathers chip read data back onto the processor's read bus. All outputs are pure functions of the present inputs. The block holds no state and has no clock.

Data moves in the same cycle as its strobes, with no handshake. The processor's strobes are the only qualifiers, so valid/ready back-pressure does not apply. Region bases and depths are parameters. An elaboration-time check rejects a base that is not aligned to its region size, and rejects two regions that overlap.

Top module: `bytelane_decoder`

## Requirements
- R1: With default parameters, byte addresses 0x480000 to 0x49FFFF (word address times two) decode to the RAM pair. Byte addresses 0x300000 to 0x307FFF decode to the ROM pair. No other address selects either pair.
- R2: In every `*_cs_n[1:0]`, `*_oe_n[1:0]` and `*_we_n[1:0]` vector, index 1 is the upper (odd-byte) chip and index 0 is the lower (even-byte) chip. Index 1 is driven low only while `cpu_ube_n` is 0, and index 0 only while `cpu_lbe_n` is 0. With both strobes low, both chips of the hit region are selected.
- R3: When both byte strobes are high, every chip select, output enable and write enable stays high, and `unmapped` stays 0, whatever the address.
- R4: A selected chip's output enable is low only while `cpu_rd_n` is 0 and `cpu_wr_n` is 1.
- R5: A selected RAM chip's write enable is low only while `cpu_wr_n` is 0. `rom_we_n` is 2'b11 at all times.
- R6: `ram_addr` equals the low 16 word-address bits, and `rom_addr` equals the low 14 word-address bits.
- R7: `ram_hi_wdata` carries `cpu_wdata[15:8]` and `ram_lo_wdata` carries `cpu_wdata[7:0]`, each only while that chip's write enable is low. Otherwise each is zero.
- R8: `cpu_rdata[15:8]` returns the upper chip's data of the region whose upper output enable is low, and `cpu_rdata[7:0]` does the same for the lower chip. A lane with no output enable asserted reads zero.
- R9: `unmapped` is 1 exactly when at least one byte strobe is low and the address lies in no region.
- R10: Every output settles in the same cycle as the inputs that drive it, with no register in any path.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| cpu_waddr | input | 23 | Word address, byte address bits 23..1 |
| cpu_ube_n | input | 1 | Upper byte strobe, active low |
| cpu_lbe_n | input | 1 | Lower byte strobe, active low |
| cpu_rd_n | input | 1 | Read strobe, active low |
| cpu_wr_n | input | 1 | Write strobe, active low |
| cpu_wdata | input | 16 | Processor write data |
| cpu_rdata | output | 16 | Processor read data, lanes gathered from the chips |
| ram_addr | output | 16 | Chip address to both RAM chips |
| ram_cs_n | output | 2 | RAM chip selects, [1] upper, [0] lower |
| ram_oe_n | output | 2 | RAM output enables |
| ram_we_n | output | 2 | RAM write enables |
| ram_hi_wdata | output | 8 | Write data to the upper RAM chip |
| ram_lo_wdata | output | 8 | Write data to the lower RAM chip |
| ram_hi_rdata | input | 8 | Read data from the upper RAM chip |
| ram_lo_rdata | input | 8 | Read data from the lower RAM chip |
| rom_addr | output | 14 | Chip address to both ROM chips |
| rom_cs_n | output | 2 | ROM chip selects |
| rom_oe_n | output | 2 | ROM output enables |
| rom_we_n | output | 2 | ROM write enables, held high |
| rom_hi_rdata | input | 8 | Read data from the upper ROM chip |
| rom_lo_rdata | input | 8 | Read data from the lower ROM chip |
| unmapped | output | 1 | Strobed access outside every region |

## Verification
The bench aims at the first and last words of each region and at the words just outside them. A wrong tag width or base would select a chip there or raise `unmapped` by mistake. Single-byte accesses on each lane catch swapped strobe polarity or swapped lane indices: the wrong chip would be enabled and the read byte would arrive on the wrong half of `cpu_rdata`. Writes aimed at the ROM catch a missing write suppression, and accesses with no strobe catch a decoder that selects on the address alone. Random addresses and strobe mixes, checked against a behavioural model on every clock, cover the rest.

// File: rtl/bytelane_pkg.sv
package bytelane_pkg;
  localparam int LANES   = 2;
  localparam int LANE_LO = 0;
  localparam int LANE_HI = 1;
  localparam int BYTE_W  = 8;

  // byte span of a region whose chips have wbits address lines each
  function automatic longint region_span(input int wbits);
    return longint'(1) << (wbits + 1);
  endfunction

  function automatic bit base_aligned(input longint base, input int wbits);
    return (base % region_span(wbits)) == 0;
  endfunction

  function automatic bit spans_disjoint(input longint b0, input int w0,
                                        input longint b1, input int w1);
    return (b0 + region_span(w0) <= b1) || (b1 + region_span(w1) <= b0);
  endfunction
endpackage

// File: rtl/bl_region_match.sv
module bl_region_match #(
  parameter int          WADDR_W = 23,
  parameter int          WBITS   = 16,
  parameter logic [23:0] BASE    = 24'h480000
) (
  input  logic [WADDR_W-1:0] waddr,
  output logic               hit,
  output logic [WBITS-1:0]   chip_addr
);
  localparam int TAG_W = WADDR_W - WBITS;
  localparam logic [TAG_W-1:0] TAG = BASE[WADDR_W:WBITS+1];

  always_comb begin
    hit       = (waddr[WADDR_W-1:WBITS] == TAG);
    chip_addr = waddr[WBITS-1:0];
  end
endmodule

// File: rtl/bl_lane_ctl.sv
module bl_lane_ctl
  import bytelane_pkg::*;
#(
  parameter bit WRITABLE = 1'b1
) (
  input  logic             hit,
  input  logic [LANES-1:0] be_n,
  input  logic             rd_n,
  input  logic             wr_n,
  output logic [LANES-1:0] cs_n,
  output logic [LANES-1:0] oe_n,
  output logic [LANES-1:0] we_n
);
  logic is_read;
  logic is_write;

  assign is_read  = !rd_n && wr_n;
  assign is_write = !wr_n && WRITABLE;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic lane_sel;
    assign lane_sel = hit && !be_n[l];
    assign cs_n[l]  = !lane_sel;
    assign oe_n[l]  = !(lane_sel && is_read);
    assign we_n[l]  = !(lane_sel && is_write);
  end

  always_comb begin
    AST_OE_WE_APART: assert ((oe_n | we_n) == '1); // R4
  end
endmodule

// File: rtl/bl_read_steer.sv
module bl_read_steer
  import bytelane_pkg::*;
(
  input  logic [LANES-1:0]        ram_oe_n,
  input  logic [LANES-1:0]        rom_oe_n,
  input  logic [LANES*BYTE_W-1:0] ram_rdata,
  input  logic [LANES*BYTE_W-1:0] rom_rdata,
  output logic [LANES*BYTE_W-1:0] cpu_rdata
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    always_comb begin
      if (!ram_oe_n[l])
        cpu_rdata[l*BYTE_W +: BYTE_W] = ram_rdata[l*BYTE_W +: BYTE_W];
      else if (!rom_oe_n[l])
        cpu_rdata[l*BYTE_W +: BYTE_W] = rom_rdata[l*BYTE_W +: BYTE_W];
      else
        cpu_rdata[l*BYTE_W +: BYTE_W] = '0;
    end
  end
endmodule

// File: rtl/bytelane_decoder.sv
module bytelane_decoder
  import bytelane_pkg::*;
#(
  parameter int          WADDR_W   = 23,
  parameter int          RAM_WBITS = 16,
  parameter logic [23:0] RAM_BASE  = 24'h480000,
  parameter int          ROM_WBITS = 14,
  parameter logic [23:0] ROM_BASE  = 24'h300000
) (
  input  logic [WADDR_W-1:0]   cpu_waddr,
  input  logic                 cpu_ube_n,
  input  logic                 cpu_lbe_n,
  input  logic                 cpu_rd_n,
  input  logic                 cpu_wr_n,
  input  logic [15:0]          cpu_wdata,
  output logic [15:0]          cpu_rdata,
  output logic [RAM_WBITS-1:0] ram_addr,
  output logic [1:0]           ram_cs_n,
  output logic [1:0]           ram_oe_n,
  output logic [1:0]           ram_we_n,
  output logic [7:0]           ram_hi_wdata,
  output logic [7:0]           ram_lo_wdata,
  input  logic [7:0]           ram_hi_rdata,
  input  logic [7:0]           ram_lo_rdata,
  output logic [ROM_WBITS-1:0] rom_addr,
  output logic [1:0]           rom_cs_n,
  output logic [1:0]           rom_oe_n,
  output logic [1:0]           rom_we_n,
  input  logic [7:0]           rom_hi_rdata,
  input  logic [7:0]           rom_lo_rdata,
  output logic                 unmapped
);
  logic [LANES-1:0] be_n;
  logic             ram_hit;
  logic             rom_hit;

  assign be_n[LANE_HI] = cpu_ube_n;
  assign be_n[LANE_LO] = cpu_lbe_n;

  initial begin
    AST_RAM_ALIGNED: assert (base_aligned(longint'(RAM_BASE), RAM_WBITS))
      else $error("RAM base not aligned to its size"); // R1
    AST_ROM_ALIGNED: assert (base_aligned(longint'(ROM_BASE), ROM_WBITS))
      else $error("ROM base not aligned to its size"); // R1
    AST_NO_OVERLAP: assert (spans_disjoint(longint'(RAM_BASE), RAM_WBITS,
                                           longint'(ROM_BASE), ROM_WBITS))
      else $error("regions overlap"); // R1
  end

  bl_region_match #(.WADDR_W(WADDR_W), .WBITS(RAM_WBITS), .BASE(RAM_BASE)) u_ram_match (
    .waddr(cpu_waddr), .hit(ram_hit), .chip_addr(ram_addr)
  );

  bl_region_match #(.WADDR_W(WADDR_W), .WBITS(ROM_WBITS), .BASE(ROM_BASE)) u_rom_match (
    .waddr(cpu_waddr), .hit(rom_hit), .chip_addr(rom_addr)
  );

  bl_lane_ctl #(.WRITABLE(1'b1)) u_ram_ctl (
    .hit(ram_hit), .be_n(be_n), .rd_n(cpu_rd_n), .wr_n(cpu_wr_n),
    .cs_n(ram_cs_n), .oe_n(ram_oe_n), .we_n(ram_we_n)
  );

  bl_lane_ctl #(.WRITABLE(1'b0)) u_rom_ctl (
    .hit(rom_hit), .be_n(be_n), .rd_n(cpu_rd_n), .wr_n(cpu_wr_n),
    .cs_n(rom_cs_n), .oe_n(rom_oe_n), .we_n(rom_we_n)
  );

  bl_read_steer u_steer (
    .ram_oe_n(ram_oe_n), .rom_oe_n(rom_oe_n),
    .ram_rdata({ram_hi_rdata, ram_lo_rdata}),
    .rom_rdata({rom_hi_rdata, rom_lo_rdata}),
    .cpu_rdata(cpu_rdata)
  );

  assign ram_hi_wdata = ram_we_n[LANE_HI] ? 8'h00 : cpu_wdata[15:8];
  assign ram_lo_wdata = ram_we_n[LANE_LO] ? 8'h00 : cpu_wdata[7:0];
  assign unmapped     = !(cpu_ube_n && cpu_lbe_n) && !ram_hit && !rom_hit;

  always_comb begin
    AST_ONE_REGION: assert (!((ram_cs_n != 2'b11) && (rom_cs_n != 2'b11))); // R1
    AST_HI_NEEDS_UBE: assert (cpu_ube_n == 1'b0 || (ram_cs_n[1] && rom_cs_n[1])); // R2
    AST_LO_NEEDS_LBE: assert (cpu_lbe_n == 1'b0 || (ram_cs_n[0] && rom_cs_n[0])); // R2
    AST_ROM_NO_WRITE: assert (rom_we_n == 2'b11); // R5
    AST_UNMAPPED_QUIET: assert (!unmapped || (ram_cs_n == 2'b11 && rom_cs_n == 2'b11)); // R9
  end
endmodule

// File: tb/bytelane_decoder_test.sv
module bytelane_decoder_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic [22:0] cpu_waddr = '0;
  logic        cpu_ube_n = 1'b1, cpu_lbe_n = 1'b1, cpu_rd_n = 1'b1, cpu_wr_n = 1'b1;
  logic [15:0] cpu_wdata = '0;
  logic [15:0] cpu_rdata;
  logic [15:0] ram_addr;
  logic [13:0] rom_addr;
  logic [1:0]  ram_cs_n, ram_oe_n, ram_we_n, rom_cs_n, rom_oe_n, rom_we_n;
  logic [7:0]  ram_hi_wdata, ram_lo_wdata;
  logic [7:0]  ram_hi_rdata = 8'h00, ram_lo_rdata = 8'h00;
  logic [7:0]  rom_hi_rdata = 8'h00, rom_lo_rdata = 8'h00;
  logic        unmapped;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  bytelane_decoder uut (
    .cpu_waddr(cpu_waddr), .cpu_ube_n(cpu_ube_n), .cpu_lbe_n(cpu_lbe_n),
    .cpu_rd_n(cpu_rd_n), .cpu_wr_n(cpu_wr_n), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .ram_addr(ram_addr), .ram_cs_n(ram_cs_n),
    .ram_oe_n(ram_oe_n), .ram_we_n(ram_we_n), .ram_hi_wdata(ram_hi_wdata),
    .ram_lo_wdata(ram_lo_wdata), .ram_hi_rdata(ram_hi_rdata),
    .ram_lo_rdata(ram_lo_rdata), .rom_addr(rom_addr), .rom_cs_n(rom_cs_n),
    .rom_oe_n(rom_oe_n), .rom_we_n(rom_we_n), .rom_hi_rdata(rom_hi_rdata),
    .rom_lo_rdata(rom_lo_rdata), .unmapped(unmapped)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h (byte addr 0x%0h)",
               req, act, exp, int'(cpu_waddr) * 2);
    end
  endtask

  // behavioural reference, compared after the inputs settle
  task automatic compare();
    int  ba;
    bit  in_ram, in_rom, rd, wr;
    bit  lane_on [2];
    int  e_ram_cs, e_ram_oe, e_ram_we, e_rom_cs, e_rom_oe, e_rdata, e_hi_w, e_lo_w;
    ba      = int'(cpu_waddr) * 2;
    in_ram  = (ba >= 'h480000) && (ba <= 'h49FFFF);
    in_rom  = (ba >= 'h300000) && (ba <= 'h307FFF);
    lane_on[1] = !cpu_ube_n;
    lane_on[0] = !cpu_lbe_n;
    rd = !cpu_rd_n && cpu_wr_n;
    wr = !cpu_wr_n;
    e_ram_cs = 3; e_ram_oe = 3; e_ram_we = 3; e_rom_cs = 3; e_rom_oe = 3;
    e_rdata = 0;
    for (int l = 0; l < 2; l++) begin
      if (in_ram && lane_on[l]) begin
        e_ram_cs &= ~(1 << l);
        if (rd) e_ram_oe &= ~(1 << l);
        if (wr) e_ram_we &= ~(1 << l);
      end
      if (in_rom && lane_on[l]) begin
        e_rom_cs &= ~(1 << l);
        if (rd) e_rom_oe &= ~(1 << l);
      end
    end
    if (!e_ram_oe[1]) e_rdata += int'(ram_hi_rdata) * 256;
    else if (!e_rom_oe[1]) e_rdata += int'(rom_hi_rdata) * 256;
    if (!e_ram_oe[0]) e_rdata += int'(ram_lo_rdata);
    else if (!e_rom_oe[0]) e_rdata += int'(rom_lo_rdata);
    e_hi_w = e_ram_we[1] ? 0 : int'(cpu_wdata) / 256;
    e_lo_w = e_ram_we[0] ? 0 : int'(cpu_wdata) % 256;
    chk("R1/R2 ram_cs_n", int'(ram_cs_n), e_ram_cs);
    chk("R1/R2 rom_cs_n", int'(rom_cs_n), e_rom_cs);
    chk("R4 ram_oe_n", int'(ram_oe_n), e_ram_oe);
    chk("R4 rom_oe_n", int'(rom_oe_n), e_rom_oe);
    chk("R5 ram_we_n", int'(ram_we_n), e_ram_we);
    chk("R5 rom_we_n", int'(rom_we_n), 3);
    chk("R6 ram_addr", int'(ram_addr), int'(cpu_waddr) % 65536);
    chk("R6 rom_addr", int'(rom_addr), int'(cpu_waddr) % 16384);
    chk("R7 ram_hi_wdata", int'(ram_hi_wdata), e_hi_w);
    chk("R7 ram_lo_wdata", int'(ram_lo_wdata), e_lo_w);
    chk("R8 cpu_rdata", int'(cpu_rdata), e_rdata);
    chk("R9 unmapped", int'(unmapped),
        int'((lane_on[0] || lane_on[1]) && !in_ram && !in_rom));
  endtask

  // drive on a rising edge, compare at the next falling edge (R10: same cycle)
  task automatic access(input int baddr, input bit ube_n, input bit lbe_n,
                        input bit rd_n, input bit wr_n, input logic [15:0] wd);
    @(posedge clk);
    cpu_waddr    = 23'(baddr / 2);
    cpu_ube_n    = ube_n;
    cpu_lbe_n    = lbe_n;
    cpu_rd_n     = rd_n;
    cpu_wr_n     = wr_n;
    cpu_wdata    = wd;
    ram_hi_rdata = 8'($urandom);
    ram_lo_rdata = 8'($urandom);
    rom_hi_rdata = 8'($urandom);
    rom_lo_rdata = 8'($urandom);
    @(negedge clk);
    compare();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // idle state, all strobes high (R3)
    compare();
    rst = 1'b0;
    // R1 edges of RAM: read word at first / last, neighbours outside
    access('h480000, 0, 0, 0, 1, 16'h0000);
    access('h49FFFE, 0, 0, 0, 1, 16'h0000);
    access('h47FFFE, 0, 0, 0, 1, 16'h0000);
    access('h4A0000, 0, 0, 0, 1, 16'h0000);
    // R1 edges of ROM
    access('h300000, 0, 0, 0, 1, 16'h0000);
    access('h307FFE, 0, 0, 0, 1, 16'h0000);
    access('h308000, 0, 0, 0, 1, 16'h0000);
    access('h2FFFFE, 0, 0, 0, 1, 16'h0000);
    // R2 single-lane reads and writes
    access('h481234, 0, 1, 0, 1, 16'h0000);
    access('h481234, 1, 0, 0, 1, 16'h0000);
    access('h48ABCE, 0, 1, 1, 0, 16'hBEEF);
    access('h48ABCE, 1, 0, 1, 0, 16'hCAFE);
    access('h48ABCE, 0, 0, 1, 0, 16'h1357);
    // R3 strobes high inside both regions
    access('h485000, 1, 1, 0, 1, 16'h0000);
    access('h301000, 1, 1, 1, 0, 16'hFFFF);
    // R5 write aimed at ROM
    access('h304444, 0, 0, 1, 0, 16'hA5A5);
    // R4 read and write both low
    access('h486000, 0, 0, 0, 0, 16'h5A5A);
    // R9 unmapped with a single strobe, and with none
    access('h000000, 1, 0, 0, 1, 16'h0000);
    access('hFFFFFE, 1, 1, 0, 1, 16'h0000);
    // random sweep around both regions and beyond
    for (int i = 0; i < 400; i++) begin
      int b;
      case (i % 3)
        0: b = 'h470000 + int'($urandom % 'h40000);
        1: b = 'h2F8000 + int'($urandom % 'h18000);
        default: b = int'($urandom % 'h1000000);
      endcase
      access(b & ~1, bit'($urandom), bit'($urandom), bit'($urandom),
             bit'($urandom), 16'($urandom));
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule